// File: doc/BRIEF.md
# Memory Access Protection Controller

This block holds the protection state of four memory regions: main flash, test flash, data EEPROM and external memory. Each region has an access-protect flag, and the three internal regions also have a write-protect flag. Software changes the flags through a register write port. Every write carries a tag that says which memory the writing instruction was fetched from. Each flag has its own rule for which writers may lift it, so code running from an unprotected place cannot open a region it has no right to.

A read path passes memory data through a one-stage valid/ready buffer. The stage replaces the data with all ones in two cases:

- a DMA read targets a region whose access protection is set;
- any read targets the control registers, which are write-only.

Upstream may present a read whenever it likes. The stage accepts it when `rd_in_ready` is high, and `rd_in_ready` equals "output empty or output being taken this cycle". Downstream may hold `rd_out_ready` low for any number of cycles. While it does, the output word and its valid stay put.

A password compare path watches writes to the password register. It clears a status flag when a write follows an earlier password write and its low bits match the stored two-bit field. The stored field itself is an input.

Top module: `memprot_ctrl`

## Requirements
- R1: The external-memory access flag (ap_flag[3]) is cleared only by a set-protection write of 1 to bit 3 of the access register (address 0), issued from EEPROM (src 2) or RAM (src 3), with temporary unprotection enabled.
- R2: The EEPROM access flag (ap_flag[2]) is cleared only by a set-protection write of 1 to bit 2 of the access register, issued from EEPROM (src 2), with temporary unprotection enabled.
- R3: The main-flash and test-flash access flags (ap_flag[0], ap_flag[1]) are cleared only by a direct write (wr_setprot=0) of 1 to bit 0 or bit 1 of the access register, issued from that same memory (src 0 or src 1 respectively), with temporary unprotection enabled.
- R4: A set-protection write sets every flag of the addressed register whose data bit is 0. A direct write of 0 changes nothing.
- R5: A write-protect flag (wp_flag[i], register address 1, bit i) is cleared by any write, of either kind and from any source, with 1 in bit i, whether or not temporary unprotection is enabled.
- R6: A write that asks to clear a flag that is set, and is refused by the rule for that flag, leaves the flag set and raises `viol` for exactly the one cycle after the write.
- R7: A DMA read of a region whose access flag is set returns FFh. A CPU read, or a DMA read of an unprotected region, returns the memory data unchanged.
- R8: A read marked as a control-register read (rd_in_reg=1) returns FFh.
- R9: `pw_ok` is cleared by a password-register write (address 2) that immediately follows another password-register write and whose bits [1:0] equal `pwd_field`. A non-matching second write re-arms nothing and leaves `pw_ok` set. Once cleared, `pw_ok` stays low until reset.
- R10: While `rst_n` is low at a clock edge:
  - the access flags load from `nv_ap`, the write flags from `nv_wp`, and the temporary-unprotect enable from `nv_tmp_en`;
  - `pw_ok` becomes 1 and `viol` becomes 0.
- R11: Reads leave the stage in acceptance order. `rd_in_ready` is high exactly when the output is empty or taken in that cycle. A stalled output holds its valid and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, loads configuration |
| nv_ap | input | 4 | Non-volatile initial access flags, 1 = protected |
| nv_wp | input | 3 | Non-volatile initial write flags, 1 = protected |
| nv_tmp_en | input | 1 | Option allowing temporary access unprotection |
| pwd_field | input | 2 | Stored password field |
| wr_en | input | 1 | Register write strobe |
| wr_setprot | input | 1 | 1 = set-protection operation, 0 = direct write |
| wr_src | input | 2 | Fetch source: 0 main flash, 1 test flash, 2 EEPROM, 3 RAM/other |
| wr_addr | input | ADDR_W | 0 access register, 1 write register, 2 password |
| wr_data | input | DATA_W | Write data |
| rd_in_valid | input | 1 | Read word offered |
| rd_in_ready | output | 1 | Stage can take a word |
| rd_in_region | input | 2 | Region of the read, indexes ap_flag |
| rd_in_dma | input | 1 | Read is issued by DMA |
| rd_in_reg | input | 1 | Read targets the control registers |
| rd_in_data | input | DATA_W | Data from memory |
| rd_out_valid | output | 1 | Result word present |
| rd_out_ready | input | 1 | Consumer takes the word |
| rd_out_data | output | DATA_W | Data or forced FFh |
| ap_flag | output | 4 | Access-protect flags |
| wp_flag | output | 3 | Write-protect flags |
| pw_ok | output | 1 | Password status flag |
| viol | output | 1 | One-cycle refused-write pulse |

## Verification
The hardest situation to reach is a set-protection write that both re-protects one flag and is refused on another. It needs an earlier, correctly sourced write that has already opened the first flag. The stimulus therefore walks a fixed sequence:

1. Open main flash from its own source.
2. Issue set-protection writes from the wrong source, with 0 in the open bit.
3. Check that the refusal pulse and the re-protection land in the same cycle.

A second reset with the enable option off and a mixed configuration covers refusals that do not depend on the source. Read traffic runs under an irregular consumer-ready pattern, so the forced value is taken from the protection state at acceptance while the output is stalled.

// File: rtl/memprot_pkg.sv
package memprot_pkg;

  localparam int NUM_REGION = 4;
  localparam int NUM_WP     = 3;

  localparam int ADR_ACCESS = 0;
  localparam int ADR_WRITE  = 1;
  localparam int ADR_PASS   = 2;

  typedef enum logic [1:0] {
    SRC_MAIN = 2'd0,
    SRC_TEST = 2'd1,
    SRC_EEP  = 2'd2,
    SRC_RAM  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    RULE_ANY,          // any writer, any operation
    RULE_DIRECT_SELF,  // direct write from the owning memory
    RULE_SETP_SELF,    // set-protection from the owning memory
    RULE_SETP_NOFLASH  // set-protection from non-flash internal memory
  } rule_e;

  function automatic rule_e access_rule(input int idx);
    case (idx)
      0, 1:    return RULE_DIRECT_SELF;
      2:       return RULE_SETP_SELF;
      default: return RULE_SETP_NOFLASH;
    endcase
  endfunction

  function automatic src_e access_owner(input int idx);
    case (idx)
      0:       return SRC_MAIN;
      1:       return SRC_TEST;
      2:       return SRC_EEP;
      default: return SRC_RAM;
    endcase
  endfunction

endpackage

// File: rtl/memprot_cell.sv
module memprot_cell
  import memprot_pkg::*;
#(
  parameter rule_e RULE  = RULE_ANY,
  parameter src_e  OWNER = SRC_RAM
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_prot,
  input  logic wr_hit,
  input  logic setprot,
  input  logic wbit,
  input  src_e src,
  input  logic tmp_en,
  output logic prot,
  output logic deny
);

  logic eligible;
  logic clr_req;
  logic restore;

  always_comb begin
    case (RULE)
      RULE_ANY:          eligible = 1'b1;
      RULE_DIRECT_SELF:  eligible = tmp_en && !setprot && (src == OWNER);
      RULE_SETP_SELF:    eligible = tmp_en && setprot && (src == OWNER);
      RULE_SETP_NOFLASH: eligible = tmp_en && setprot &&
                                    (src == SRC_EEP || src == SRC_RAM);
      default:           eligible = 1'b0;
    endcase
  end

  assign clr_req = wr_hit && wbit;
  assign restore = wr_hit && setprot && !wbit;
  assign deny    = clr_req && !eligible && prot;

  always_ff @(posedge clk) begin
    if (!rst_n)                    prot <= init_prot;
    else if (restore)              prot <= 1'b1;
    else if (clr_req && eligible)  prot <= 1'b0;
  end

endmodule

// File: rtl/memprot_bank.sv
module memprot_bank
  import memprot_pkg::*;
#(
  parameter int NBITS   = 4,
  parameter bit WP_BANK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] init_prot,
  input  logic             wr_hit,
  input  logic             setprot,
  input  logic [NBITS-1:0] wbits,
  input  src_e             src,
  input  logic             tmp_en,
  output logic [NBITS-1:0] prot,
  output logic             deny_any
);

  logic [NBITS-1:0] deny_vec;

  for (genvar g = 0; g < NBITS; g++) begin : g_cell
    localparam rule_e CELL_RULE  = WP_BANK ? RULE_ANY : access_rule(g);
    localparam src_e  CELL_OWNER = access_owner(g);
    memprot_cell #(
      .RULE  (CELL_RULE),
      .OWNER (CELL_OWNER)
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_prot (init_prot[g]),
      .wr_hit    (wr_hit),
      .setprot   (setprot),
      .wbit      (wbits[g]),
      .src       (src),
      .tmp_en    (tmp_en),
      .prot      (prot[g]),
      .deny      (deny_vec[g])
    );
  end

  assign deny_any = |deny_vec;

endmodule

// File: rtl/memprot_pwd.sv
module memprot_pwd #(
  parameter int PWD_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pw_hit,
  input  logic [PWD_W-1:0] pw_data,
  input  logic [PWD_W-1:0] pw_field,
  output logic             pw_ok
);

  logic armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pw_ok <= 1'b1;
    end else if (pw_hit) begin
      armed <= !armed;
      if (armed && (pw_data == pw_field)) pw_ok <= 1'b0;
    end
  end

endmodule

// File: rtl/memprot_rdstage.sv
module memprot_rdstage #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int RW    = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREG-1:0]   ap,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [RW-1:0]     in_region,
  input  logic              in_dma,
  input  logic              in_reg,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam logic [DATA_W-1:0] FORCED = '1;

  logic blocked;
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign blocked  = in_reg || (in_dma && ap[in_region]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= blocked ? FORCED : in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/memprot_ctrl.sv
module memprot_ctrl
  import memprot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2,
  parameter int PWD_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_REGION-1:0] nv_ap,
  input  logic [NUM_WP-1:0]     nv_wp,
  input  logic                  nv_tmp_en,
  input  logic [PWD_W-1:0]      pwd_field,
  input  logic                  wr_en,
  input  logic                  wr_setprot,
  input  logic [1:0]            wr_src,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_in_valid,
  output logic                  rd_in_ready,
  input  logic [1:0]            rd_in_region,
  input  logic                  rd_in_dma,
  input  logic                  rd_in_reg,
  input  logic [DATA_W-1:0]     rd_in_data,
  output logic                  rd_out_valid,
  input  logic                  rd_out_ready,
  output logic [DATA_W-1:0]     rd_out_data,
  output logic [NUM_REGION-1:0] ap_flag,
  output logic [NUM_WP-1:0]     wp_flag,
  output logic                  pw_ok,
  output logic                  viol
);

  localparam logic [ADDR_W-1:0] A_ACC = ADDR_W'(ADR_ACCESS);
  localparam logic [ADDR_W-1:0] A_WP  = ADDR_W'(ADR_WRITE);
  localparam logic [ADDR_W-1:0] A_PW  = ADDR_W'(ADR_PASS);

  logic tmp_en_q;
  logic hit_acc, hit_wp, hit_pw;
  logic deny_acc, deny_wp;
  src_e src;
  logic unused_wdata;

  assign src          = src_e'(wr_src);
  assign hit_acc      = wr_en && (wr_addr == A_ACC);
  assign hit_wp       = wr_en && (wr_addr == A_WP);
  assign hit_pw       = wr_en && (wr_addr == A_PW);
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmp_en_q <= nv_tmp_en;
      viol     <= 1'b0;
    end else begin
      viol     <= deny_acc || deny_wp;
    end
  end

  memprot_bank #(.NBITS(NUM_REGION), .WP_BANK(1'b0)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_prot (nv_ap),
    .wr_hit    (hit_acc),
    .setprot   (wr_setprot),
    .wbits     (wr_data[NUM_REGION-1:0]),
    .src       (src),
    .tmp_en    (tmp_en_q),
    .prot      (ap_flag),
    .deny_any  (deny_acc)
  );

  memprot_bank #(.NBITS(NUM_WP), .WP_BANK(1'b1)) u_wp (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_prot (nv_wp),
    .wr_hit    (hit_wp),
    .setprot   (wr_setprot),
    .wbits     (wr_data[NUM_WP-1:0]),
    .src       (src),
    .tmp_en    (tmp_en_q),
    .prot      (wp_flag),
    .deny_any  (deny_wp)
  );

  memprot_pwd #(.PWD_W(PWD_W)) u_pwd (
    .clk      (clk),
    .rst_n    (rst_n),
    .pw_hit   (hit_pw),
    .pw_data  (wr_data[PWD_W-1:0]),
    .pw_field (pwd_field),
    .pw_ok    (pw_ok)
  );

  memprot_rdstage #(.DATA_W(DATA_W), .NREG(NUM_REGION)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ap        (ap_flag),
    .in_valid  (rd_in_valid),
    .in_ready  (rd_in_ready),
    .in_region (rd_in_region),
    .in_dma    (rd_in_dma),
    .in_reg    (rd_in_reg),
    .in_data   (rd_in_data),
    .out_valid (rd_out_valid),
    .out_ready (rd_out_ready),
    .out_data  (rd_out_data)
  );

endmodule

// File: rtl/memprot_ctrl_chk.sv
module memprot_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nv_tmp_en,
  input logic              wr_en,
  input logic              wr_setprot,
  input logic [1:0]        wr_src,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_in_valid,
  input logic              rd_in_ready,
  input logic              rd_in_reg,
  input logic              rd_out_valid,
  input logic              rd_out_ready,
  input logic [DATA_W-1:0] rd_out_data,
  input logic [3:0]        ap_flag,
  input logic [2:0]        wp_flag,
  input logic              pw_ok,
  input logic              viol
);

  logic warm, en_seen, reg_item;
  logic acc_wr, wp_wr;

  assign acc_wr = wr_en && (wr_addr == ADDR_W'(0));
  assign wp_wr  = wr_en && (wr_addr == ADDR_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      warm     <= 1'b0;
      en_seen  <= nv_tmp_en;
      reg_item <= 1'b0;
    end else begin
      warm <= 1'b1;
      if (rd_in_valid && rd_in_ready) reg_item <= rd_in_reg;
    end
  end

  p_ext_clear_r1: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $fell(ap_flag[3]) |-> $past(acc_wr && wr_setprot && wr_data[3] && en_seen &&
                                (wr_src == 2'd2 || wr_src == 2'd3)));

  p_eep_clear_r2: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $fell(ap_flag[2]) |-> $past(acc_wr && wr_setprot && wr_data[2] && en_seen &&
                                wr_src == 2'd2));

  p_main_clear_r3: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $fell(ap_flag[0]) |-> $past(acc_wr && !wr_setprot && wr_data[0] && en_seen &&
                                wr_src == 2'd0));

  p_test_clear_r3: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $fell(ap_flag[1]) |-> $past(acc_wr && !wr_setprot && wr_data[1] && en_seen &&
                                wr_src == 2'd1));

  p_acc_restore_r4: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $rose(ap_flag[0]) |-> $past(acc_wr && wr_setprot && !wr_data[0]));

  p_wp_restore_r4: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $rose(wp_flag[0]) |-> $past(wp_wr && wr_setprot && !wr_data[0]));

  p_wp_clear_r5: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    $fell(wp_flag[2]) |-> $past(wp_wr && wr_data[2]));

  p_viol_cause_r6: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    viol |-> $past(wr_en && (acc_wr || wp_wr)));

  p_regread_ff_r8: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (rd_out_valid && reg_item) |-> (rd_out_data == '1));

  p_pwok_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    !pw_ok |=> !pw_ok);

  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n || !warm)
    (rd_out_valid && !rd_out_ready) |=> (rd_out_valid && $stable(rd_out_data)));

  p_ready_rule_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in_ready == (!rd_out_valid || rd_out_ready));

endmodule

bind memprot_ctrl memprot_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .nv_tmp_en    (nv_tmp_en),
  .wr_en        (wr_en),
  .wr_setprot   (wr_setprot),
  .wr_src       (wr_src),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .rd_in_valid  (rd_in_valid),
  .rd_in_ready  (rd_in_ready),
  .rd_in_reg    (rd_in_reg),
  .rd_out_valid (rd_out_valid),
  .rd_out_ready (rd_out_ready),
  .rd_out_data  (rd_out_data),
  .ap_flag      (ap_flag),
  .wp_flag      (wp_flag),
  .pw_ok        (pw_ok),
  .viol         (viol)
);

// File: tb/memprot_ctrl_tb_top.sv
module memprot_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nv_ap = 4'hF;
  logic [2:0] nv_wp = 3'h7;
  logic       nv_tmp_en = 1'b1;
  logic [1:0] pwd_field = 2'b10;
  logic       wr_en = 1'b0, wr_setprot = 1'b0;
  logic [1:0] wr_src = '0, wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_in_valid = 1'b0, rd_in_ready;
  logic [1:0] rd_in_region = '0;
  logic       rd_in_dma = 1'b0, rd_in_reg = 1'b0;
  logic [7:0] rd_in_data = '0;
  logic       rd_out_valid, rd_out_ready = 1'b1;
  logic [7:0] rd_out_data;
  logic [3:0] ap_flag;
  logic [2:0] wp_flag;
  logic       pw_ok, viol;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] rdy_pat = 8'hB5;

  always #(CLK_PERIOD/2) clk = ~clk;

  memprot_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .nv_ap(nv_ap), .nv_wp(nv_wp), .nv_tmp_en(nv_tmp_en),
    .pwd_field(pwd_field), .wr_en(wr_en), .wr_setprot(wr_setprot), .wr_src(wr_src),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_in_valid(rd_in_valid),
    .rd_in_ready(rd_in_ready), .rd_in_region(rd_in_region), .rd_in_dma(rd_in_dma),
    .rd_in_reg(rd_in_reg), .rd_in_data(rd_in_data), .rd_out_valid(rd_out_valid),
    .rd_out_ready(rd_out_ready), .rd_out_data(rd_out_data), .ap_flag(ap_flag),
    .wp_flag(wp_flag), .pw_ok(pw_ok), .viol(viol)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] ap0, input logic [2:0] wp0, input logic en0);
    nv_ap = ap0; nv_wp = wp0; nv_tmp_en = en0;
    @(posedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] addr, input logic sp, input logic [1:0] src,
                    input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = addr; wr_setprot = sp; wr_src = src; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  // driver: pushes the expected word, then offers the read
  task automatic rd(input logic [1:0] reg_n, input logic dma, input logic isreg,
                    input logic [7:0] d, input logic [7:0] exp);
    exp_q.push_back(exp);
    @(posedge clk); #1;
    rd_in_valid = 1'b1; rd_in_region = reg_n; rd_in_dma = dma;
    rd_in_reg = isreg; rd_in_data = d;
    forever begin
      @(negedge clk);
      if (rd_in_ready) break;
    end
    @(posedge clk); #1;
    rd_in_valid = 1'b0;
  endtask

  // irregular consumer
  always @(posedge clk) begin
    #1;
    rdy_pat      = {rdy_pat[6:0], rdy_pat[7] ^ rdy_pat[5]};
    rd_out_ready = rdy_pat[0];
  end

  // monitor: pops the scoreboard as words leave (R7 R8 R11)
  always @(negedge clk) begin
    if (rst_n && rd_out_valid && rd_out_ready) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R11: actual unexpected word %0h expected none", rd_out_data);
      end else begin
        check("R7/R8/R11 read word", rd_out_data, exp_q.pop_front());
      end
    end
  end

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    check("R11 queue drained", exp_q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset(4'hF, 3'h7, 1'b1);
    check("R10 ap reset", ap_flag, 4'hF);
    check("R10 wp reset", wp_flag, 3'h7);
    check("R10 pw_ok reset", pw_ok, 1'b1);
    check("R10 viol reset", viol, 1'b0);

    rd(2'd0, 1'b1, 1'b0, 8'h5A, 8'hFF);          // R7 protected DMA
    rd(2'd0, 1'b0, 1'b0, 8'h5A, 8'h5A);          // R7 CPU read
    rd(2'd2, 1'b0, 1'b1, 8'h33, 8'hFF);          // R8 register read
    drain();

    wr(2'd0, 1'b0, 2'd1, 8'h01);                 // wrong source
    check("R3 main kept from test src", ap_flag, 4'hF);
    check("R6 viol on refused", viol, 1'b1);
    @(negedge clk);
    check("R6 viol one cycle", viol, 1'b0);

    wr(2'd0, 1'b0, 2'd0, 8'h01);
    check("R3 main opened from self", ap_flag, 4'hE);
    check("R6 no viol on allowed", viol, 1'b0);
    rd(2'd0, 1'b1, 1'b0, 8'hA5, 8'hA5);          // R7 unprotected DMA
    rd(2'd1, 1'b1, 1'b0, 8'hA5, 8'hFF);
    drain();

    wr(2'd0, 1'b0, 2'd2, 8'h04);                 // direct write cannot open EEPROM
    check("R2 eep kept on direct", ap_flag, 4'hE);
    check("R6 viol direct eep", viol, 1'b1);

    wr(2'd0, 1'b1, 2'd0, 8'h04);                 // wrong src, also re-protects bit 0
    check("R2/R4 eep kept, main restored", ap_flag, 4'hF);
    check("R6 viol setprot eep", viol, 1'b1);

    wr(2'd0, 1'b1, 2'd2, 8'h04);
    check("R2 eep opened from self", ap_flag, 4'hB);

    wr(2'd0, 1'b1, 2'd1, 8'h08);                 // test flash may not open ext
    check("R1/R4 ext kept, eep restored", ap_flag, 4'hF);
    check("R1 viol", viol, 1'b1);

    wr(2'd0, 1'b1, 2'd3, 8'h08);
    check("R1 ext opened from RAM", ap_flag, 4'h7);

    wr(2'd0, 1'b0, 2'd3, 8'h00);
    check("R4 direct zero no effect", ap_flag, 4'h7);
    check("R4 direct zero no viol", viol, 1'b0);

    rd(2'd3, 1'b1, 1'b0, 8'hC3, 8'hC3);
    rd(2'd2, 1'b1, 1'b0, 8'hC3, 8'hFF);
    rd(2'd3, 1'b0, 1'b1, 8'hC3, 8'hFF);
    rd(2'd1, 1'b0, 1'b0, 8'h3C, 8'h3C);
    drain();

    wr(2'd1, 1'b0, 2'd3, 8'h02);
    check("R5 wp opened any src", wp_flag, 3'h5);
    wr(2'd1, 1'b1, 2'd0, 8'h00);
    check("R4 wp restored", wp_flag, 3'h7);

    wr(2'd2, 1'b0, 2'd3, 8'h02);                 // first write alone
    check("R9 first write keeps ok", pw_ok, 1'b1);
    wr(2'd2, 1'b0, 2'd3, 8'h01);                 // second, no match
    check("R9 mismatch keeps ok", pw_ok, 1'b1);
    wr(2'd2, 1'b0, 2'd3, 8'h00);
    wr(2'd2, 1'b0, 2'd3, 8'h02);
    check("R9 matching second clears ok", pw_ok, 1'b0);
    check("R9 ap untouched", ap_flag, 4'h7);

    do_reset(4'h5, 3'h3, 1'b0);
    check("R10 ap from config", ap_flag, 4'h5);
    check("R10 wp from config", wp_flag, 3'h3);
    check("R10 pw_ok back", pw_ok, 1'b1);
    wr(2'd0, 1'b0, 2'd0, 8'h01);
    check("R3 option off refuses", ap_flag, 4'h5);
    check("R6 viol option off", viol, 1'b1);
    wr(2'd1, 1'b0, 2'd2, 8'h01);
    check("R5 wp ignores option", wp_flag, 3'h2);

    finish_run();
  end

endmodule